// File: doc/BRIEF.md
# Level-Masked Priority Interrupt Controller

This block gathers up to `NUM_SRC` level-sensitive interrupt lines and presents one request line and a vector number to a processor. A source can reach the processor only when two things are true. Its own enable bit must be set, and the current priority level must let it through. At level L, only sources numbered below L may interrupt. Level 0 therefore blocks everything, and level `NUM_SRC` lets every enabled source through. Among the sources that pass both gates, the lowest-numbered one wins.

Software uses a small register bus. Each access lasts one cycle, reads are combinational and writes commit on the clock edge. A claim read returns the winner's vector and the level that was in force before the claim. In the same cycle it raises the level to the winner's number, so only more urgent sources can preempt the handler. The level before the claim is pushed onto a hardware stack. A restore write pops that stack back into the level register, so nested handlers unwind without software having to keep the saved level. No acknowledge cycle exists: a source's pending bit follows its line.

Register map (word addresses on `bus_addr`): 0 enable-by-index (write), 1 disable-by-index (write), 2 enable mask (read), 3 pending (read), 4 level (read/write), 5 claim (read), 6 restore (write). Other addresses read as zero and ignore writes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The pending value (read at address 3, bit i for source i) has bit i set exactly when `irq_src[i]` is high, enable bit i is set and i is less than the current level.
- R2: `irq_vec` is registered. One cycle after any change, it equals `VEC_BASE` plus the lowest index with a pending bit set, and it is 0 while nothing is pending.
- R3: `irq_out` is registered and equals the OR of all pending bits as they were one cycle earlier.
- R4: The level (read at address 4, low bits) ranges over 0 to `NUM_SRC`. A write to address 4 with a value in that range takes effect at the clock edge, and a larger value leaves the level unchanged.
- R5: Writing source index k to address 0 sets enable bit k, and writing k to address 1 clears it. If k ≥ `NUM_SRC`, `bus_err` is high during that access and the mask is unchanged. The mask reads back at address 2 with bit i for source i.
- R6: A claim read (address 5) while something is pending returns the vector (`VEC_BASE` + winner) in bits [7:0], the previous level in bits [23:16] and 0 in bit 31. It sets the level to the winner's index and pushes the previous level onto the stack.
- R7: A claim read while nothing is pending returns only bit 31 set. It leaves the level unchanged and pushes nothing.
- R8: A write to address 6 (data ignored) pops the most recently pushed level into the level register. When the stack is empty, `stk_unf` is high during that access and the level is unchanged.
- R9: The stack holds `STACK_DEPTH` (default 8) levels. A successful claim while it is full drives `stk_ovf` high during that access, drops the push and still changes the level.
- R10: After reset, every enable bit is clear, the level is `NUM_SRC`, the stack is empty and `irq_out`/`irq_vec` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | NUM_SRC | Level-sensitive source lines, bit i is source i |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Enable/disable index out of range, in the access cycle |
| stk_ovf | output | 1 | Claim pushed onto a full stack |
| stk_unf | output | 1 | Restore from an empty stack |
| irq_out | output | 1 | Registered interrupt request |
| irq_vec | output | VEC_W | Registered vector of the current winner |

## Verification
The bench builds the block with `NUM_SRC` = 8, `VEC_BASE` = 16 and the default stack depth of 8. With eight sources, every source pattern can be driven at every one of the nine levels, over a spread of enable masks. The non-zero base shows that the vector is an addition and not just the index. Eight sources also give exactly eight strictly nested claims, from level 8 down to level 0, which fills the stack. That makes overflow, a full unwind and underflow reachable in a short directed sequence.

// File: rtl/pic_pkg.sv
// pic_pkg: shared register addresses and claim-word field positions for
// the level-masked priority interrupt controller.
// Assumes a 4-bit word address and a 32-bit data bus.
package pic_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    // Register word addresses (software visible)
    typedef enum logic [ADDR_W-1:0] {
        RA_EN_SET  = 4'd0,
        RA_EN_CLR  = 4'd1,
        RA_EN_MASK = 4'd2,
        RA_PEND    = 4'd3,
        RA_LEVEL   = 4'd4,
        RA_CLAIM   = 4'd5,
        RA_RESTORE = 4'd6
    } reg_addr_e;

    // Claim word layout
    localparam int CLM_PREV_LSB = 16;
    localparam int CLM_NONE_BIT = 31;

endpackage

// File: rtl/pic_mask.sv
// pic_mask: combines source lines, per-source enables and the threshold
// implied by the current level into the pending vector.
// Assumes level never exceeds NUM_SRC; bit i passes only if i < level.
module pic_mask #(
    parameter int NUM_SRC = 32,
    parameter int LVL_W   = $clog2(NUM_SRC + 1)
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] en,
    input  logic [LVL_W-1:0]   level,
    output logic [NUM_SRC-1:0] pend
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRC; gi++) begin : g_bit
            // Per-source gate: line, enable and threshold must all agree
            assign pend[gi] = src[gi] & en[gi] & (LVL_W'(gi) < level);
        end
    endgenerate

endmodule

// File: rtl/pic_prio_enc.sv
// pic_prio_enc: fixed-priority encoder, lowest index wins.
// Assumes nothing about the request pattern; idx is 0 when none is set.
module pic_prio_enc #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [IDX_W-1:0]   idx,
    output logic               any
);

    // Scan from the top so the lowest set index is the last one written
    always_comb begin
        idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // Any request present
    assign any = |req;

endmodule

// File: rtl/pic_level_stack.sv
// pic_level_stack: LIFO of saved priority levels for nested claims.
// Assumes the caller never pushes when full or pops when empty; such
// requests are ignored here and flagged by the parent.
module pic_level_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);
    assign top   = empty ? '0 : mem[PTR_W'(cnt - 1'b1)];

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + 1'b1;
        else if (pop && !empty)
            cnt <= cnt - 1'b1;
    end

    // Storage write at the next free slot
    always_ff @(posedge clk) begin
        if (push && !full)
            mem[PTR_W'(cnt)] <= din;
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// prio_irq_ctrl: level-masked priority interrupt controller.
// Decodes a single-cycle register bus, holds the enable mask and current
// level, picks the lowest-numbered pending source, registers the request
// and vector, and nests claims through a hardware level stack.
// Assumes 2 <= NUM_SRC <= 32, VEC_W <= 16 and LVL_W <= 8.
module prio_irq_ctrl #(
    parameter int NUM_SRC     = 32,
    parameter int VEC_BASE    = 0,
    parameter int VEC_W       = 8,
    parameter int STACK_DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         irq_src,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [pic_pkg::ADDR_W-1:0] bus_addr,
    input  logic [pic_pkg::DATA_W-1:0] bus_wdata,
    output logic [pic_pkg::DATA_W-1:0] bus_rdata,
    output logic                       bus_err,
    output logic                       stk_ovf,
    output logic                       stk_unf,
    output logic                       irq_out,
    output logic [VEC_W-1:0]           irq_vec
);
    import pic_pkg::*;

    localparam int LVL_W = $clog2(NUM_SRC + 1);
    localparam int IDX_W = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0] en_q;
    logic [LVL_W-1:0]   level_q;
    logic [NUM_SRC-1:0] pend;
    logic [IDX_W-1:0]   win_idx;
    logic               any;
    logic [VEC_W-1:0]   vec_now;
    logic [LVL_W-1:0]   stk_top;
    logic               stk_full;
    logic               stk_empty;

    logic acc_wr, acc_rd;
    logic en_set, en_clr, idx_ok;
    logic lvl_wr, lvl_ok;
    logic claim_rd, claim_go, restore;

    // Bus decode
    assign acc_wr   = bus_sel & bus_wr;
    assign acc_rd   = bus_sel & ~bus_wr;
    assign en_set   = acc_wr & (bus_addr == RA_EN_SET);
    assign en_clr   = acc_wr & (bus_addr == RA_EN_CLR);
    assign lvl_wr   = acc_wr & (bus_addr == RA_LEVEL);
    assign restore  = acc_wr & (bus_addr == RA_RESTORE);
    assign claim_rd = acc_rd & (bus_addr == RA_CLAIM);
    assign idx_ok   = (bus_wdata < DATA_W'(NUM_SRC));
    assign lvl_ok   = (bus_wdata <= DATA_W'(NUM_SRC));
    assign claim_go = claim_rd & any;

    // Error and stack condition flags for the current access
    assign bus_err = (en_set | en_clr) & ~idx_ok;
    assign stk_ovf = claim_go & stk_full;
    assign stk_unf = restore & stk_empty;

    // Masking stage
    pic_mask #(
        .NUM_SRC (NUM_SRC),
        .LVL_W   (LVL_W)
    ) u_mask (
        .src   (irq_src),
        .en    (en_q),
        .level (level_q),
        .pend  (pend)
    );

    // Priority selection
    pic_prio_enc #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_enc (
        .req (pend),
        .idx (win_idx),
        .any (any)
    );

    assign vec_now = VEC_W'(VEC_BASE) + VEC_W'(win_idx);

    // Saved-level stack
    pic_level_stack #(
        .DEPTH (STACK_DEPTH),
        .W     (LVL_W)
    ) u_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (claim_go & ~stk_full),
        .pop   (restore & ~stk_empty),
        .din   (level_q),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    // Per-source enable mask, changed one index at a time
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (en_set && idx_ok)
            en_q[bus_wdata[IDX_W-1:0]] <= 1'b1;
        else if (en_clr && idx_ok)
            en_q[bus_wdata[IDX_W-1:0]] <= 1'b0;
    end

    // Current level: claim raises it, restore pops, direct write sets it
    always_ff @(posedge clk) begin
        if (!rst_n)
            level_q <= LVL_W'(NUM_SRC);
        else if (claim_go)
            level_q <= LVL_W'(win_idx);
        else if (restore && !stk_empty)
            level_q <= stk_top;
        else if (lvl_wr && lvl_ok)
            level_q <= bus_wdata[LVL_W-1:0];
    end

    // Registered request and vector toward the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
            irq_vec <= '0;
        end else begin
            irq_out <= any;
            irq_vec <= any ? vec_now : '0;
        end
    end

    // Read data mux, zero outside a read access
    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            case (bus_addr)
                RA_EN_MASK: bus_rdata[NUM_SRC-1:0] = en_q;
                RA_PEND:    bus_rdata[NUM_SRC-1:0] = pend;
                RA_LEVEL:   bus_rdata[LVL_W-1:0]   = level_q;
                RA_CLAIM: begin
                    if (any) begin
                        bus_rdata[VEC_W-1:0]                = vec_now;
                        bus_rdata[CLM_PREV_LSB +: LVL_W]    = level_q;
                    end else begin
                        bus_rdata[CLM_NONE_BIT]             = 1'b1;
                    end
                end
                default:    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pic_checker.sv
// pic_checker: temporal properties of prio_irq_ctrl, bound to every
// instance. Assumes the same parameter values as the bound instance.
module pic_checker #(
    parameter int NUM_SRC     = 32,
    parameter int VEC_W       = 8,
    parameter int STACK_DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_SRC-1:0]         irq_src,
    input logic                       bus_sel,
    input logic                       bus_wr,
    input logic [pic_pkg::ADDR_W-1:0] bus_addr,
    input logic [pic_pkg::DATA_W-1:0] bus_wdata,
    input logic                       bus_err,
    input logic                       stk_ovf,
    input logic                       stk_unf,
    input logic                       irq_out,
    input logic [NUM_SRC-1:0]         en_q,
    input logic [$clog2(NUM_SRC+1)-1:0] level_q,
    input logic [NUM_SRC-1:0]         pend,
    input logic [$clog2(NUM_SRC)-1:0] win_idx,
    input logic                       any,
    input logic                       stk_full
);
    import pic_pkg::*;

    localparam int LVL_W = $clog2(NUM_SRC + 1);

    logic               claim_rd, lvl_bad;
    logic [NUM_SRC-1:0] below_win;

    assign claim_rd = bus_sel & ~bus_wr & (bus_addr == RA_CLAIM);
    assign lvl_bad  = bus_sel & bus_wr & (bus_addr == RA_LEVEL)
                    & (bus_wdata > DATA_W'(NUM_SRC));

    // Bits strictly below the selected index
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            below_win[i] = (i < int'(win_idx));
    end

    assert_pend_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~(irq_src & en_q)) == '0);

    assert_winner_lowest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> (pend[win_idx] && ((pend & below_win) == '0)));

    assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|pend)));

    assert_level_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= LVL_W'(NUM_SRC));

    assert_bad_level_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_bad |=> $stable(level_q));

    assert_bad_index_keeps_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> $stable(en_q));

    assert_claim_sets_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && any) |=> (level_q == LVL_W'($past(win_idx))));

    assert_empty_claim_keeps_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd && !any) |=> $stable(level_q));

    assert_underflow_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf |=> $stable(level_q));

    assert_overflow_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf |-> (stk_full && claim_rd));

endmodule

bind prio_irq_ctrl pic_checker #(
    .NUM_SRC     (NUM_SRC),
    .VEC_W       (VEC_W),
    .STACK_DEPTH (STACK_DEPTH)
) u_pic_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (irq_src),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_err   (bus_err),
    .stk_ovf   (stk_ovf),
    .stk_unf   (stk_unf),
    .irq_out   (irq_out),
    .en_q      (en_q),
    .level_q   (level_q),
    .pend      (pend),
    .win_idx   (win_idx),
    .any       (any),
    .stk_full  (stk_full)
);

// File: tb/prio_irq_ctrl_test.sv
// prio_irq_ctrl_test: sweeps levels, enable masks and all source patterns
// of an 8-source build, then walks the nesting stack through fill,
// overflow, unwind and underflow.
module prio_irq_ctrl_test;

    localparam int N    = 8;
    localparam int BASE = 16;
    localparam int VW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_src = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err, stk_ovf, stk_unf, irq_out;
    logic [VW-1:0] irq_vec;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    prio_irq_ctrl #(
        .NUM_SRC (N), .VEC_BASE (BASE), .VEC_W (VW), .STACK_DEPTH (8)
    ) uut (
        .clk (clk), .rst_n (rst_n), .irq_src (irq_src),
        .bus_sel (bus_sel), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_err (bus_err),
        .stk_ovf (stk_ovf), .stk_unf (stk_unf),
        .irq_out (irq_out), .irq_vec (irq_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle, entered and left at a falling edge
    task automatic access(input bit wr, input logic [3:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output logic e,
                          output logic ov, output logic un);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        rd = bus_rdata; e = bus_err; ov = stk_ovf; un = stk_unf;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    function automatic int lowest(input logic [N-1:0] p);
        int r = 0;
        for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
        return r;
    endfunction

    initial begin
        logic [31:0] rd;
        logic e, ov, un;
        logic [N-1:0] mask, expp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 irq_out", 32'(irq_out), 0);
        chk("R10 irq_vec", 32'(irq_vec), 0);
        access(0, 4'd2, 0, rd, e, ov, un); chk("R10 enable mask", rd, 0);
        access(0, 4'd4, 0, rd, e, ov, un); chk("R10 level", rd, N);
        access(1, 4'd6, 0, rd, e, ov, un); chk("R10 stack empty", 32'(un), 1);

        // R1/R2/R3/R4/R5 sweep
        for (int lv = 0; lv <= N; lv++) begin
            access(1, 4'd4, lv, rd, e, ov, un);
            access(0, 4'd4, 0, rd, e, ov, un); chk("R4 level write", rd, lv);
            for (int m = 0; m < 16; m++) begin
                mask = N'((m * 23) ^ (lv * 77) ^ 8'h5a);
                for (int i = 0; i < N; i++)
                    access(1, mask[i] ? 4'd0 : 4'd1, i, rd, e, ov, un);
                access(0, 4'd2, 0, rd, e, ov, un); chk("R5 mask readback", rd, 32'(mask));
                for (int s = 0; s < 256; s++) begin
                    irq_src = N'(s);
                    expp = N'(s) & mask & N'((1 << lv) - 1);
                    access(0, 4'd3, 0, rd, e, ov, un);
                    chk("R1 pending", rd, 32'(expp));
                    chk("R3 irq_out", 32'(irq_out), 32'(expp != 0));
                    chk("R2 irq_vec", 32'(irq_vec), (expp != 0) ? BASE + lowest(expp) : 0);
                end
            end
        end

        // R4: out-of-range level writes ignored
        access(1, 4'd4, 5, rd, e, ov, un);
        access(1, 4'd4, N + 1, rd, e, ov, un);
        access(0, 4'd4, 0, rd, e, ov, un); chk("R4 level N+1 ignored", rd, 5);
        access(1, 4'd4, 32'hffff_ffff, rd, e, ov, un);
        access(0, 4'd4, 0, rd, e, ov, un); chk("R4 level huge ignored", rd, 5);

        // R5: index range errors
        for (int i = 0; i < N; i++) access(1, 4'd0, i, rd, e, ov, un);
        chk("R5 valid index no error", 32'(e), 0);
        access(1, 4'd1, N, rd, e, ov, un); chk("R5 disable index N error", 32'(e), 1);
        access(1, 4'd0, 100, rd, e, ov, un); chk("R5 enable index 100 error", 32'(e), 1);
        access(0, 4'd2, 0, rd, e, ov, un); chk("R5 mask unchanged", rd, 32'hff);

        // R6: nested claims fill the stack
        access(1, 4'd4, N, rd, e, ov, un);
        for (int k = 0; k < N; k++) begin
            irq_src = N'(8'hff << (N - 1 - k));
            access(0, 4'd5, 0, rd, e, ov, un);
            chk("R6 claim word", rd, ((N - k) << 16) | (BASE + N - 1 - k));
            chk("R9 no overflow while filling", 32'(ov), 0);
        end
        access(0, 4'd4, 0, rd, e, ov, un); chk("R6 level after claims", rd, 0);

        // R7: empty claim at level 0
        access(0, 4'd5, 0, rd, e, ov, un); chk("R7 none flag", rd, 32'h8000_0000);
        access(0, 4'd4, 0, rd, e, ov, un); chk("R7 level kept", rd, 0);

        // R9: claim on a full stack
        access(1, 4'd4, N, rd, e, ov, un);
        access(0, 4'd5, 0, rd, e, ov, un);
        chk("R9 overflow flag", 32'(ov), 1);
        chk("R9 claim word", rd, (N << 16) | BASE);
        access(0, 4'd4, 0, rd, e, ov, un); chk("R9 level still changed", rd, 0);

        // R8: unwind then underflow
        for (int k = 1; k <= N; k++) begin
            access(1, 4'd6, 32'hdead, rd, e, ov, un);
            chk("R8 no underflow", 32'(un), 0);
            access(0, 4'd4, 0, rd, e, ov, un); chk("R8 restored level", rd, k);
        end
        access(1, 4'd6, 0, rd, e, ov, un); chk("R8 underflow flag", 32'(un), 1);
        access(0, 4'd4, 0, rd, e, ov, un); chk("R8 level kept", rd, N);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule